// File: doc/BRIEF.md
# Clock Mode and Fallback Controller

This synchronous controller decides how a small microcontroller is clocked. Low-power requests (wait, stop) and a wake event move it between run, wait and two stop flavours. Configuration bits choose whether the PLL is dropped during wait, whether stop keeps the oscillator alive, and whether the watchdog and periodic timer keep ticking in that light stop. A clock-health monitor reports loss of clock. Depending on two enable bits, a loss of clock either moves the chip onto an internal fallback clock, held until an external quality check passes, or raises a reset request.

The outputs are plain control levels: oscillator enable, PLL enable, core and system clock gates, fallback select and the two timer tick enables. Each is decoded from the registered mode together with the live configuration and rate-nonzero inputs. Reset requests carry a one-hot cause. The first cause is kept until power-on reset. There is no data stream, so every pin is a plain level with no handshake.

Top module: `clkmode_ctrl`

## Requirements
- R1: In run mode the oscillator, PLL, core clock and system clock are all enabled and fallback select is low. The watchdog tick enable equals `wdt_rate_nz` and the periodic tick enable equals `pit_rate_nz`.
- R2: A wait request in run mode enters wait on the next edge. In wait the core clock is gated, the system clock and oscillator stay on, and the timers follow their rate-nonzero inputs. The PLL enable is low when `cfg_pll_off_wait` is 1 and high otherwise.
- R3: A stop request in run mode with `cfg_pseudo_stop` = 0 enters full stop. In full stop the oscillator, PLL, core and system clocks and both tick enables are all low.
- R4: A stop request in run mode with `cfg_pseudo_stop` = 1 enters light stop. In light stop the oscillator stays on, PLL, core and system clocks are off, and each tick enable is its rate-nonzero input ANDed with its run-in-stop enable.
- R5: Stop takes precedence over wait when both are requested together. Wait and stop requests are ignored in any mode other than run.
- R6: A wake event in wait or either stop mode gives one wake cycle: PLL, oscillator and system clock on, core clock still gated. Run mode follows on the next edge. A wake event in run mode has no effect.
- R7: A loss of clock with `cfg_mon_en` and `cfg_self_en` both 1 enters self-clock mode from any other mode. In self-clock mode fallback select is 1, PLL enable is 0, the oscillator, core and system clocks are on, and the timers follow their rate-nonzero inputs.
- R8: Self-clock mode is held while `clk_qual_ok` is 0 and returns to run on the edge after `clk_qual_ok` is 1.
- R9: A loss of clock with `cfg_mon_en` = 1 and `cfg_self_en` = 0 records the loss-of-clock cause and leaves the mode unchanged. With `cfg_mon_en` = 0 a loss of clock has no effect.
- R10: `rst_cause` bit 0 is illegal address, bit 1 watchdog timeout, bit 2 loss of clock and bit 3 external pin. It is one-hot, keeps the first cause seen until power-on reset, and `rst_req` is 1 whenever it is nonzero. Among causes arriving in the same cycle the highest bit wins.
- R11: After power-on reset the mode is run and `rst_cause` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low power-on reset |
| req_wait | input | 1 | Wait-mode request |
| req_stop | input | 1 | Stop-mode request |
| wake | input | 1 | Wake event |
| cfg_pll_off_wait | input | 1 | Drop PLL while waiting |
| cfg_pseudo_stop | input | 1 | 1 = light stop, 0 = full stop |
| cfg_mon_en | input | 1 | Clock monitor enable |
| cfg_self_en | input | 1 | Self-clock fallback enable |
| cfg_wdt_stop_run | input | 1 | Watchdog keeps ticking in light stop |
| cfg_pit_stop_run | input | 1 | Periodic timer keeps ticking in light stop |
| wdt_rate_nz | input | 1 | Watchdog rate field is nonzero |
| pit_rate_nz | input | 1 | Periodic timer rate field is nonzero |
| clk_lost | input | 1 | Loss-of-clock detect |
| clk_qual_ok | input | 1 | Clock quality check passed |
| ev_illegal_addr | input | 1 | Illegal address reset event |
| ev_wdt_timeout | input | 1 | Watchdog timeout reset event |
| ev_ext_pin | input | 1 | External pin reset event |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| core_clk_en | output | 1 | Core clock gate open |
| sys_clk_en | output | 1 | System clock gate open |
| fallback_sel | output | 1 | Internal fallback clock selected |
| wdt_tick_en | output | 1 | Watchdog tick enable |
| pit_tick_en | output | 1 | Periodic timer tick enable |
| rst_req | output | 1 | Reset request |
| rst_cause | output | 4 | Latched one-hot reset cause |

## Verification
The mode decode is tried with each rate-nonzero and run-in-stop combination in every mode. These patterns show whether tick enables come from the right pair of inputs. Wait is entered with the PLL-off bit at both values, and stop with both flavour settings, so a swapped decode shows up as a single wrong output level. Wake sequences are sampled cycle by cycle to catch a PLL that rises with the core gate instead of one cycle earlier. Loss of clock is applied under all three enable combinations, including from full stop. Simultaneous and sequential reset events separate the priority rule from the first-cause-kept rule.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_WAIT  = 3'd1,
    ST_FSTOP = 3'd2,
    ST_LSTOP = 3'd3,
    ST_WAKE  = 3'd4,
    ST_SELF  = 3'd5
  } cm_state_e;

  localparam int CAUSE_W = 4;
  localparam int CI_ILL  = 0;
  localparam int CI_WDT  = 1;
  localparam int CI_LOC  = 2;
  localparam int CI_EXT  = 3;

  typedef struct packed {
    logic osc;
    logic pll;
    logic core;
    logic sys;
    logic fb;
    logic wdt;
    logic pit;
  } clk_ctl_t;
endpackage

// File: rtl/clkmode_fsm.sv
module clkmode_fsm
  import clkmode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_wait,
  input  logic      req_stop,
  input  logic      wake,
  input  logic      light_stop,
  input  logic      self_go,
  input  logic      qual_ok,
  output cm_state_e state
);
  cm_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (state_q == ST_SELF) begin
      if (qual_ok) state_d = ST_RUN;
    end else if (self_go) begin
      state_d = ST_SELF;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (req_stop)      state_d = light_stop ? ST_LSTOP : ST_FSTOP;
          else if (req_wait) state_d = ST_WAIT;
        end
        ST_WAIT, ST_FSTOP, ST_LSTOP: if (wake) state_d = ST_WAKE;
        ST_WAKE: state_d = ST_RUN;
        default: state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R8: fallback mode persists without a quality pass
  a_r8_self_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SELF && !qual_ok) |=> (state_q == ST_SELF));

  // R6: wake interval lasts one cycle
  a_r6_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAKE) |=> (state_q == ST_RUN || state_q == ST_SELF));

  // R5: low-power requests are honoured only from run
  a_r5_enter_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN && !self_go && state_q != ST_SELF) |=>
      (state_q != ST_FSTOP || $past(state_q) == ST_FSTOP));
endmodule

// File: rtl/clkmode_outdec.sv
module clkmode_outdec
  import clkmode_pkg::*;
(
  input  cm_state_e state,
  input  logic      pll_off_wait,
  input  logic      wdt_stop_run,
  input  logic      pit_stop_run,
  input  logic      wdt_rate_nz,
  input  logic      pit_rate_nz,
  output clk_ctl_t  ctl
);
  always_comb begin
    ctl = '0;
    unique case (state)
      ST_RUN: begin
        ctl.osc = 1'b1; ctl.pll = 1'b1; ctl.core = 1'b1; ctl.sys = 1'b1;
        ctl.wdt = wdt_rate_nz; ctl.pit = pit_rate_nz;
      end
      ST_WAIT: begin
        ctl.osc = 1'b1; ctl.pll = !pll_off_wait; ctl.sys = 1'b1;
        ctl.wdt = wdt_rate_nz; ctl.pit = pit_rate_nz;
      end
      ST_FSTOP: ctl = '0;
      ST_LSTOP: begin
        ctl.osc = 1'b1;
        ctl.wdt = wdt_rate_nz & wdt_stop_run;
        ctl.pit = pit_rate_nz & pit_stop_run;
      end
      ST_WAKE: begin
        ctl.osc = 1'b1; ctl.pll = 1'b1; ctl.sys = 1'b1;
        ctl.wdt = wdt_rate_nz; ctl.pit = pit_rate_nz;
      end
      ST_SELF: begin
        ctl.osc = 1'b1; ctl.core = 1'b1; ctl.sys = 1'b1; ctl.fb = 1'b1;
        ctl.wdt = wdt_rate_nz; ctl.pit = pit_rate_nz;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/clkmode_cause.sv
module clkmode_cause #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  output logic [W-1:0] cause
);
  logic [W-1:0] pick, cause_q;

  always_comb begin
    pick = '0;
    for (int i = 0; i < W; i++) begin
      if (evt[i]) pick = W'(1) << i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cause_q <= '0;
    else if (cause_q == '0)  cause_q <= pick;
  end

  assign cause = cause_q;

  // R10: never more than one cause bit
  a_r10_cause_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause_q));

  // R10: first cause is kept
  a_r10_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q != '0) |=> $stable(cause_q));

  // R10: any event with nothing latched is recorded next cycle
  a_r10_cause_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cause_q == '0 && evt != '0) |=> (cause_q != '0));
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
  import clkmode_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_wait,
  input  logic               req_stop,
  input  logic               wake,
  input  logic               cfg_pll_off_wait,
  input  logic               cfg_pseudo_stop,
  input  logic               cfg_mon_en,
  input  logic               cfg_self_en,
  input  logic               cfg_wdt_stop_run,
  input  logic               cfg_pit_stop_run,
  input  logic               wdt_rate_nz,
  input  logic               pit_rate_nz,
  input  logic               clk_lost,
  input  logic               clk_qual_ok,
  input  logic               ev_illegal_addr,
  input  logic               ev_wdt_timeout,
  input  logic               ev_ext_pin,
  output logic               osc_en,
  output logic               pll_en,
  output logic               core_clk_en,
  output logic               sys_clk_en,
  output logic               fallback_sel,
  output logic               wdt_tick_en,
  output logic               pit_tick_en,
  output logic               rst_req,
  output logic [CAUSE_W-1:0] rst_cause
);
  cm_state_e          state;
  clk_ctl_t           ctl;
  logic               self_go, loc_evt;
  logic [CAUSE_W-1:0] evt;

  assign self_go = clk_lost & cfg_mon_en & cfg_self_en;
  assign loc_evt = clk_lost & cfg_mon_en & ~cfg_self_en;

  always_comb begin
    evt         = '0;
    evt[CI_ILL] = ev_illegal_addr;
    evt[CI_WDT] = ev_wdt_timeout;
    evt[CI_LOC] = loc_evt;
    evt[CI_EXT] = ev_ext_pin;
  end

  clkmode_fsm i_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_wait   (req_wait),
    .req_stop   (req_stop),
    .wake       (wake),
    .light_stop (cfg_pseudo_stop),
    .self_go    (self_go),
    .qual_ok    (clk_qual_ok),
    .state      (state)
  );

  clkmode_outdec i_dec (
    .state        (state),
    .pll_off_wait (cfg_pll_off_wait),
    .wdt_stop_run (cfg_wdt_stop_run),
    .pit_stop_run (cfg_pit_stop_run),
    .wdt_rate_nz  (wdt_rate_nz),
    .pit_rate_nz  (pit_rate_nz),
    .ctl          (ctl)
  );

  clkmode_cause #(.W(CAUSE_W)) i_cause (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt),
    .cause (rst_cause)
  );

  assign osc_en       = ctl.osc;
  assign pll_en       = ctl.pll;
  assign core_clk_en  = ctl.core;
  assign sys_clk_en   = ctl.sys;
  assign fallback_sel = ctl.fb;
  assign wdt_tick_en  = ctl.wdt;
  assign pit_tick_en  = ctl.pit;
  assign rst_req      = |rst_cause;

  // R6: PLL is already on in the cycle before the core gate opens
  a_r6_pll_before_core: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(core_clk_en) && !fallback_sel) |-> $past(pll_en));

  // R7: fallback operation keeps the PLL off
  a_r7_fallback_no_pll: assert property (@(posedge clk) disable iff (!rst_n)
    fallback_sel |-> !pll_en);

  // R3: full stop from run shuts everything down
  a_r3_full_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && !fallback_sel && req_stop && !cfg_pseudo_stop && !self_go)
      |=> (!osc_en && !sys_clk_en && !wdt_tick_en && !pit_tick_en));

  // R9: a loss reset request leaves a latched loss cause or an earlier one
  a_r9_loss_request: assert property (@(posedge clk) disable iff (!rst_n)
    loc_evt |=> rst_req);
endmodule

// File: tb/test_clkmode_ctrl.sv
module test_clkmode_ctrl;
  localparam time TCLK = 10ns;

  typedef struct packed {
    logic rw, rs, wk, poff, ps, mon, sen, wsr, psr, wnz, pnz, lost, qok, eill, ewdt, eext;
  } in_t;

  typedef struct {
    string      tag;
    logic [6:0] ctl;
    logic [3:0] cause;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  in_t  stg = '0;
  in_t  drv = '0;
  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;

  logic osc_en, pll_en, core_clk_en, sys_clk_en, fallback_sel, wdt_tick_en, pit_tick_en, rst_req;
  logic [3:0] rst_cause;

  always #(TCLK/2) clk = ~clk;

  clkmode_ctrl i_clkmode_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_wait(drv.rw), .req_stop(drv.rs), .wake(drv.wk),
    .cfg_pll_off_wait(drv.poff), .cfg_pseudo_stop(drv.ps),
    .cfg_mon_en(drv.mon), .cfg_self_en(drv.sen),
    .cfg_wdt_stop_run(drv.wsr), .cfg_pit_stop_run(drv.psr),
    .wdt_rate_nz(drv.wnz), .pit_rate_nz(drv.pnz),
    .clk_lost(drv.lost), .clk_qual_ok(drv.qok),
    .ev_illegal_addr(drv.eill), .ev_wdt_timeout(drv.ewdt), .ev_ext_pin(drv.eext),
    .osc_en(osc_en), .pll_en(pll_en), .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en),
    .fallback_sel(fallback_sel), .wdt_tick_en(wdt_tick_en), .pit_tick_en(pit_tick_en),
    .rst_req(rst_req), .rst_cause(rst_cause)
  );

  // driver: apply staged inputs after a falling edge, push expectation after the capturing edge
  task automatic go(input string tag, input logic [6:0] ctl, input logic [3:0] cause);
    exp_t e;
    @(negedge clk); #1;
    drv = stg;
    @(posedge clk); #2;
    e.tag = tag; e.ctl = ctl; e.cause = cause;
    q.push_back(e);
  endtask

  task automatic por();
    wait (q.size() == 0);
    @(negedge clk); #1;
    rst_n = 1'b0; stg = '0; drv = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    rst_n = 1'b1;
  endtask

  // monitor: compare at falling edges
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        logic [6:0] act;
        e = q.pop_front();
        act = {osc_en, pll_en, core_clk_en, sys_clk_en, fallback_sel, wdt_tick_en, pit_tick_en};
        checks++;
        if (act !== e.ctl || rst_cause !== e.cause || rst_req !== (|e.cause)) begin
          fails++;
          $display("FAIL %s: ctl=%b cause=%b req=%b expected ctl=%b cause=%b req=%b",
                   e.tag, act, rst_cause, rst_req, e.ctl, e.cause, |e.cause);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ctl order: osc pll core sys fb wdt pit
  initial begin
    por();
    go("R11 reset state run", 7'b1111000, 4'b0000);
    stg.wnz = 1; go("R1 run wdt tick", 7'b1111010, 4'b0000);
    stg.pnz = 1; go("R1 run both ticks", 7'b1111011, 4'b0000);

    stg.rw = 1; go("R2 wait pll kept", 7'b1101011, 4'b0000);
    stg.rw = 0; go("R2 wait held", 7'b1101011, 4'b0000);
    stg.rs = 1; go("R5 stop ignored in wait", 7'b1101011, 4'b0000);
    stg.rs = 0; stg.wk = 1; go("R6 wake cycle", 7'b1101011, 4'b0000);
    stg.wk = 0; go("R6 back to run", 7'b1111011, 4'b0000);

    stg.poff = 1; stg.rw = 1; go("R2 wait pll dropped", 7'b1001011, 4'b0000);
    stg.rw = 0; stg.wk = 1; go("R6 pll before core", 7'b1101011, 4'b0000);
    stg.wk = 0; go("R6 run after wake", 7'b1111011, 4'b0000);
    stg.poff = 0;

    stg.rs = 1; go("R3 full stop", 7'b0000000, 4'b0000);
    stg.rs = 0; go("R3 full stop held", 7'b0000000, 4'b0000);
    stg.wk = 1; go("R6 wake from full stop", 7'b1101011, 4'b0000);
    stg.wk = 0; go("R6 run after full stop", 7'b1111011, 4'b0000);

    stg.ps = 1; stg.wsr = 1; stg.rs = 1; stg.rw = 1;
    go("R5 stop beats wait, R4 wdt runs", 7'b1000010, 4'b0000);
    stg.rs = 0; stg.rw = 0; stg.wsr = 0; stg.psr = 1;
    go("R4 light stop pit runs", 7'b1000001, 4'b0000);
    stg.psr = 0; go("R4 light stop frozen", 7'b1000000, 4'b0000);
    stg.wk = 1; go("R6 wake from light stop", 7'b1101011, 4'b0000);
    stg.wk = 0; go("R6 run after light stop", 7'b1111011, 4'b0000);
    stg.ps = 0;

    stg.wk = 1; go("R6 wake ignored in run", 7'b1111011, 4'b0000);
    stg.wk = 0;

    stg.sen = 1; stg.lost = 1; go("R9 loss ignored monitor off", 7'b1111011, 4'b0000);
    stg.mon = 1; go("R7 enter self clock", 7'b1011111, 4'b0000);
    stg.lost = 0; go("R8 self held", 7'b1011111, 4'b0000);
    stg.qok = 1; go("R8 quality pass to run", 7'b1111011, 4'b0000);
    stg.qok = 0;

    stg.rs = 1; go("R3 full stop again", 7'b0000000, 4'b0000);
    stg.rs = 0; stg.lost = 1; go("R7 self from full stop", 7'b1011111, 4'b0000);
    stg.lost = 0; stg.qok = 1; go("R8 exit to run", 7'b1111011, 4'b0000);
    stg.qok = 0;

    stg.sen = 0; stg.lost = 1; go("R9 loss reset request", 7'b1111011, 4'b0100);
    stg.lost = 0; stg.eext = 1; go("R10 first cause kept", 7'b1111011, 4'b0100);
    stg.eext = 0; go("R10 cause held", 7'b1111011, 4'b0100);

    por();
    stg.mon = 1; stg.lost = 1; stg.eill = 1; stg.ewdt = 1; stg.eext = 1;
    go("R10 external pin priority", 7'b1111000, 4'b1000);
    por();
    stg.mon = 1; stg.lost = 1; stg.eill = 1; stg.ewdt = 1;
    go("R10 loss beats watchdog", 7'b1111000, 4'b0100);
    por();
    stg.eill = 1; stg.ewdt = 1; go("R10 watchdog priority", 7'b1111000, 4'b0010);
    por();
    stg.eill = 1; go("R10 illegal address", 7'b1111000, 4'b0001);
    stg.eill = 0; go("R10 illegal held", 7'b1111000, 4'b0001);

    wait (q.size() == 0);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule